// File: doc/BRIEF.md
# Header Field Override Sequencer

This block walks the 42 byte positions of an Ethernet/IPv4/UDP header. It starts on a single-cycle start pulse and presents one 6-bit index per clock to an external 64 x 8 header-template memory. The template memory has a registered read, so each byte comes back one clock later.

Most header bytes pass straight through from the template. Six positions are replaced by values computed from a payload length that is captured on the start pulse:

- the two bytes of the IPv4 total length;
- the two bytes of the IPv4 header checksum;
- the two bytes of the UDP length.

The checksum is not summed over the header. It is a precomputed base constant minus the payload length, which is valid because only the length field changes between frames.

The override selects are decoded from the index through a register pipeline. That pipeline is exactly as deep as the template read latency, so each patched byte lands on the cycle its template byte would have occupied. Payload muxing after byte 41 and frame delimiting belong to neighbouring logic.

Top module: `hdr_field_patcher`

## Requirements
- R1: While `rst_ni` is low, `tmpl_idx_o` is 0 and no override is selected, so `hdr_byte_o` equals `tmpl_byte_i`.
- R2: While idle with `start_i` low, `tmpl_idx_o` stays at 0.
- R3: A start pulse while idle makes `tmpl_idx_o` 1 on the next clock. It then rises by one per clock up to 41 and returns to 0 on the clock after 41.
- R4: `pay_len_i` is captured only on an accepted start. A start pulse during a sequence neither restarts the index nor recaptures the length.
- R5: The header byte for position p appears on `hdr_byte_o` in the clock after the one in which `tmpl_idx_o` shows p. This matches a one-cycle registered template read (`RD_LAT` = 1).
- R6: Positions 16 (high byte) and 17 (low byte) output the total length, which is 28 + length modulo 2^16.
- R7: Positions 24 (high byte) and 25 (low byte) output the checksum, which is `CSUM_BASE` − length modulo 2^16. The default base is 0xB77D.
- R8: Positions 38 (high byte) and 39 (low byte) output the UDP length, which is 8 + length modulo 2^16.
- R9: Every other position outputs `tmpl_byte_i` unchanged. This includes EtherType bytes 12/13 (0x08, 0x00), byte 14 (0x45), TTL byte 22 (0x40) and protocol byte 23 (0x11).
- R10: A start pulse on the clock right after the index returns to 0 is accepted, giving back-to-back headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle start pulse |
| pay_len_i | input | 16 | Payload length in bytes, sampled on an accepted start |
| tmpl_byte_i | input | 8 | Template byte read back for the previous index |
| tmpl_idx_o | output | 6 | Template read index |
| hdr_byte_o | output | 8 | Header byte after override |

## Verification
If the start pulse is captured at clock edge k, the index reads 1 after edge k, m+1 after edge k+m, and 0 again after edge k+41. The byte for position m is valid after edge k+m, one register after its index.

A driver task queues all 42 expected bytes and indices as soon as edge k has passed. A monitor pops one entry at every falling edge, so each byte is compared half a cycle after the edge that produced it. Idle and reset checks sample the index and the pass-through byte on falling edges between frames.

The stimulus includes:
- payload lengths of 0 and 0xFFFF, to exercise modulo wrap;
- a stray start pulse in mid-sequence carrying a different length;
- back-to-back frames started the clock after the index returns to 0.

// File: rtl/hdr_patch_pkg.sv
package hdr_patch_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    OVR_NONE,
    OVR_TLEN_HI,
    OVR_TLEN_LO,
    OVR_CSUM_HI,
    OVR_CSUM_LO,
    OVR_ULEN_HI,
    OVR_ULEN_LO
  } ovr_sel_e;

endpackage

// File: rtl/hdr_idx_seq.sv
module hdr_idx_seq #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned LAST_POS = 41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(LAST_POS);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign accept_o = start_i & ~busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      idx_q  <= IDX_W'(1);
    end else if (busy_q) begin
      if (idx_q == LastIdx) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/hdr_len_calc.sv
module hdr_len_calc #(
  parameter int unsigned       LEN_W     = 16,
  parameter int unsigned       TLEN_ADD  = 28,
  parameter int unsigned       ULEN_ADD  = 8,
  parameter logic [LEN_W-1:0]  CSUM_BASE = 16'hB77D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] tlen_o,
  output logic [LEN_W-1:0] csum_o,
  output logic [LEN_W-1:0] ulen_o
);

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (load_i) len_q <= len_i;
  end

  // Only the length field varies between frames, so the checksum is base minus length
  assign tlen_o = len_q + LEN_W'(TLEN_ADD);
  assign ulen_o = len_q + LEN_W'(ULEN_ADD);
  assign csum_o = CSUM_BASE - len_q;

endmodule

// File: rtl/hdr_ovr_decode.sv
module hdr_ovr_decode
  import hdr_patch_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned RD_LAT   = 1,
  parameter int unsigned TLEN_POS = 16,
  parameter int unsigned CSUM_POS = 24,
  parameter int unsigned ULEN_POS = 38
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output ovr_sel_e         sel_o
);

  ovr_sel_e sel_c;
  ovr_sel_e sel_q [RD_LAT];

  always_comb begin
    sel_c = OVR_NONE;
    if      (idx_i == IDX_W'(TLEN_POS))     sel_c = OVR_TLEN_HI;
    else if (idx_i == IDX_W'(TLEN_POS + 1)) sel_c = OVR_TLEN_LO;
    else if (idx_i == IDX_W'(CSUM_POS))     sel_c = OVR_CSUM_HI;
    else if (idx_i == IDX_W'(CSUM_POS + 1)) sel_c = OVR_CSUM_LO;
    else if (idx_i == IDX_W'(ULEN_POS))     sel_c = OVR_ULEN_HI;
    else if (idx_i == IDX_W'(ULEN_POS + 1)) sel_c = OVR_ULEN_LO;
  end

  // One stage per cycle of template read latency
  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sel_q[s] <= OVR_NONE;
        else         sel_q[s] <= sel_c;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sel_q[s] <= OVR_NONE;
        else         sel_q[s] <= sel_q[s-1];
      end
    end
  end

  assign sel_o = sel_q[RD_LAT-1];

endmodule

// File: rtl/hdr_field_patcher.sv
module hdr_field_patcher
  import hdr_patch_pkg::*;
#(
  parameter int unsigned      IDX_W     = 6,
  parameter int unsigned      HDR_BYTES = 42,
  parameter int unsigned      LEN_W     = 16,
  parameter int unsigned      RD_LAT    = 1,
  parameter int unsigned      TLEN_POS  = 16,
  parameter int unsigned      CSUM_POS  = 24,
  parameter int unsigned      ULEN_POS  = 38,
  parameter int unsigned      TLEN_ADD  = 28,
  parameter int unsigned      ULEN_ADD  = 8,
  parameter logic [LEN_W-1:0] CSUM_BASE = 16'hB77D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  pay_len_i,
  input  logic [BYTE_W-1:0] tmpl_byte_i,
  output logic [IDX_W-1:0]  tmpl_idx_o,
  output logic [BYTE_W-1:0] hdr_byte_o
);

  localparam int unsigned LAST_POS = HDR_BYTES - 1;

  logic             accept;
  logic [LEN_W-1:0] tlen, csum, ulen;
  ovr_sel_e         sel;

  hdr_idx_seq #(
    .IDX_W   (IDX_W),
    .LAST_POS(LAST_POS)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .idx_o   (tmpl_idx_o)
  );

  hdr_len_calc #(
    .LEN_W    (LEN_W),
    .TLEN_ADD (TLEN_ADD),
    .ULEN_ADD (ULEN_ADD),
    .CSUM_BASE(CSUM_BASE)
  ) u_len (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .len_i (pay_len_i),
    .tlen_o(tlen),
    .csum_o(csum),
    .ulen_o(ulen)
  );

  hdr_ovr_decode #(
    .IDX_W   (IDX_W),
    .RD_LAT  (RD_LAT),
    .TLEN_POS(TLEN_POS),
    .CSUM_POS(CSUM_POS),
    .ULEN_POS(ULEN_POS)
  ) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (tmpl_idx_o),
    .sel_o (sel)
  );

  always_comb begin
    unique case (sel)
      OVR_TLEN_HI: hdr_byte_o = tlen[LEN_W-1 -: BYTE_W];
      OVR_TLEN_LO: hdr_byte_o = tlen[BYTE_W-1:0];
      OVR_CSUM_HI: hdr_byte_o = csum[LEN_W-1 -: BYTE_W];
      OVR_CSUM_LO: hdr_byte_o = csum[BYTE_W-1:0];
      OVR_ULEN_HI: hdr_byte_o = ulen[LEN_W-1 -: BYTE_W];
      OVR_ULEN_LO: hdr_byte_o = ulen[BYTE_W-1:0];
      default:     hdr_byte_o = tmpl_byte_i;
    endcase
  end

endmodule

// File: rtl/hdr_field_patcher_chk.sv
module hdr_field_patcher_chk #(
  parameter int unsigned      IDX_W     = 6,
  parameter int unsigned      HDR_BYTES = 42,
  parameter int unsigned      LEN_W     = 16,
  parameter int unsigned      RD_LAT    = 1,
  parameter int unsigned      TLEN_POS  = 16,
  parameter int unsigned      CSUM_POS  = 24,
  parameter int unsigned      ULEN_POS  = 38,
  parameter int unsigned      TLEN_ADD  = 28,
  parameter int unsigned      ULEN_ADD  = 8,
  parameter logic [LEN_W-1:0] CSUM_BASE = 16'hB77D
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] pay_len_i,
  input logic [7:0]       tmpl_byte_i,
  input logic [IDX_W-1:0] tmpl_idx_o,
  input logic [7:0]       hdr_byte_o
);

  localparam logic [IDX_W-1:0] Last = IDX_W'(HDR_BYTES - 1);

  // Length as seen by the checker: captured when a start arrives at index 0
  logic [LEN_W-1:0] len_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          len_seen <= '0;
    else if (start_i && tmpl_idx_o == '0) len_seen <= pay_len_i;
  end

  logic [LEN_W-1:0] exp_tlen, exp_csum, exp_ulen;
  assign exp_tlen = len_seen + LEN_W'(TLEN_ADD);
  assign exp_csum = CSUM_BASE - len_seen;
  assign exp_ulen = len_seen + LEN_W'(ULEN_ADD);

  p_reset_idx_r1: assert property (@(posedge clk_i) !rst_ni |-> tmpl_idx_o == '0);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmpl_idx_o == '0 && !start_i) |=> tmpl_idx_o == '0);

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmpl_idx_o == '0 && start_i) |=> tmpl_idx_o == IDX_W'(1));

  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmpl_idx_o != '0 && tmpl_idx_o != Last) |=> tmpl_idx_o == $past(tmpl_idx_o) + IDX_W'(1));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmpl_idx_o == Last |=> tmpl_idx_o == '0);

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmpl_idx_o <= Last);

  if (RD_LAT == 1) begin : g_lat1
    function automatic logic is_ovr(input logic [IDX_W-1:0] p);
      return p == IDX_W'(TLEN_POS) || p == IDX_W'(TLEN_POS + 1) ||
             p == IDX_W'(CSUM_POS) || p == IDX_W'(CSUM_POS + 1) ||
             p == IDX_W'(ULEN_POS) || p == IDX_W'(ULEN_POS + 1);
    endfunction

    p_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_ovr($past(tmpl_idx_o)) |-> hdr_byte_o == tmpl_byte_i);

    p_tlen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(tmpl_idx_o) == IDX_W'(TLEN_POS) |-> hdr_byte_o == exp_tlen[LEN_W-1 -: 8]);

    p_csum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(tmpl_idx_o) == IDX_W'(CSUM_POS + 1) |-> hdr_byte_o == exp_csum[7:0]);

    p_ulen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(tmpl_idx_o) == IDX_W'(ULEN_POS + 1) |-> hdr_byte_o == exp_ulen[7:0]);
  end

endmodule

bind hdr_field_patcher hdr_field_patcher_chk #(
  .IDX_W    (IDX_W),
  .HDR_BYTES(HDR_BYTES),
  .LEN_W    (LEN_W),
  .RD_LAT   (RD_LAT),
  .TLEN_POS (TLEN_POS),
  .CSUM_POS (CSUM_POS),
  .ULEN_POS (ULEN_POS),
  .TLEN_ADD (TLEN_ADD),
  .ULEN_ADD (ULEN_ADD),
  .CSUM_BASE(CSUM_BASE)
) u_chk (.*);

// File: tb/hdr_field_patcher_test.sv
`timescale 1ns/1ps
module hdr_field_patcher_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] pay_len;
  logic [7:0]  tmpl_q;
  logic [5:0]  idx;
  logic [7:0]  hdr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] b;
    logic [5:0] ix;
    int         pos;
  } exp_t;
  exp_t q[$];

  logic [7:0] tmem [64];

  always #4 clk = ~clk;

  hdr_field_patcher uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .pay_len_i  (pay_len),
    .tmpl_byte_i(tmpl_q),
    .tmpl_idx_o (idx),
    .hdr_byte_o (hdr)
  );

  // Template memory model: registered read, one clock of latency
  always_ff @(posedge clk) tmpl_q <= tmem[idx];

  initial begin
    for (int i = 0; i < 64; i++) tmem[i] = 8'((i * 37 + 5) ^ 8'h5A);
    tmem[12] = 8'h08; tmem[13] = 8'h00; tmem[14] = 8'h45;
    tmem[22] = 8'h40; tmem[23] = 8'h11;
  end

  function automatic logic [7:0] exp_byte(input int pos, input logic [15:0] len);
    logic [15:0] tl, cs, ul;
    tl = len + 16'd28;
    cs = 16'hB77D - len;
    ul = len + 16'd8;
    case (pos)
      16: return tl[15:8];
      17: return tl[7:0];
      24: return cs[15:8];
      25: return cs[7:0];
      38: return ul[15:8];
      39: return ul[7:0];
      default: return tmem[pos];
    endcase
  endfunction

  function automatic string tag(input int pos);
    case (pos)
      16, 17:  return "R6 R5";
      24, 25:  return "R7 R5";
      38, 39:  return "R8 R5";
      default: return "R9 R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: one expected header byte per falling edge while the queue has entries
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        chk($sformatf("%s byte pos %0d", tag(e.pos), e.pos), 16'(hdr), 16'(e.b));
        chk($sformatf("R3 index after pos %0d", e.pos), 16'(idx), 16'(e.ix));
      end
    end
  end

  // Driver: called at a falling edge; returns at the falling edge after the last header byte
  task automatic run_frame(input logic [15:0] len, input bit intr, input logic [15:0] ilen);
    start   = 1'b1;
    pay_len = len;
    @(posedge clk);
    for (int m = 0; m < 42; m++) begin
      exp_t e;
      e.pos = m;
      e.b   = exp_byte(m, len);
      e.ix  = (m == 41) ? 6'd0 : 6'(m + 1);
      q.push_back(e);
    end
    @(negedge clk);
    start   = 1'b0;
    pay_len = ~len;
    for (int m = 1; m <= 41; m++) begin
      @(negedge clk);
      if (intr && m == 10) begin  // R4: stray start with another length mid-sequence
        start   = 1'b1;
        pay_len = ilen;
      end
      if (m == 11) start = 1'b0;
    end
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 idle index", 16'(idx), 16'd0);
      chk("R2 idle pass-through", 16'(hdr), 16'(tmem[0]));
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    pay_len = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 index in reset", 16'(idx), 16'd0);
    chk("R1 pass-through in reset", 16'(hdr), 16'(tmem[0]));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 index after reset", 16'(idx), 16'd0);
    pay_len = 16'h1234;
    idle_check(4);

    run_frame(16'd0, 1'b0, 16'd0);
    idle_check(3);
    run_frame(16'd16, 1'b0, 16'd0);
    idle_check(2);
    run_frame(16'd1500, 1'b0, 16'd0);
    idle_check(2);
    run_frame(16'hFFFF, 1'b0, 16'd0);
    idle_check(2);
    run_frame(16'd100, 1'b1, 16'd777);  // R4: length must stay 100
    idle_check(2);
    run_frame(16'd200, 1'b0, 16'd0);    // R10: next start on the following clock
    run_frame(16'd300, 1'b0, 16'd0);
    idle_check(5);

    chk("R10 queue drained", 16'(q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule